// File: doc/BRIEF.md
# DMA Channel Control Register with Enable Sideband

This block is the control/status register of one peripheral DMA channel, sitting on a plain 32-bit register bus. A write to it can request a reset of the attached SCSI controller, a FIFO drain, and a change of the channel enable. The block stores the resulting word. Read-only status positions keep their hardware-driven values, and a fixed version code is merged into every readback.

Two sideband outputs go to the attached controller. The first is a single-cycle reset pulse. The second is a level that follows the enable bit, and it moves only when a write actually changes that bit. The attached controller can therefore hold back a queued command until the channel is really enabled.

Top module: `chan_ctl_reg`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_data` equals the version code (default 0xA000_0000) OR-ed with the status bits, `dev_rst` is low and `xfer_en` is low.
- R2: A write stores its data into the writable positions, which are all bits outside the read-only mask (default 0xFE00_0007). A readback in the next cycle shows the stored bits.
- R3: The version code is present in `rd_data` in every cycle.
- R4: A write with bit 7 (reset command) set drives `dev_rst` high for exactly the next cycle. The written value, including bits 7 and 6, is stored unmodified.
- R5: A write with bit 7 clear and bit 6 (drain) set is stored with bit 6 cleared.
- R6: A write of all zeros is stored as if only bit 6 (0x40) had been written. A nonzero write whose writable bits are all zero is stored as zero.
- R7: A write with bit 9 (enable) set while the stored enable is 0 raises `xfer_en` in the next cycle.
- R8: A write with bit 9 clear while the stored enable is 1 lowers `xfer_en` in the next cycle. Writes that leave bit 9 unchanged, and idle cycles, leave `xfer_en` as it was.
- R9: Bit 0 reads back `irq_pend` and bit 26 reads back `buf_loaded`, each registered by one cycle. Write data never changes these two bits or any other read-only bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| irq_pend | input | 1 | Interrupt-pending status, shown in bit 0 |
| buf_loaded | input | 1 | Loaded status, shown in bit 26 |
| rd_data | output | 32 | Current register value; reading has no side effect |
| dev_rst | output | 1 | One-cycle reset pulse to the attached controller |
| xfer_en | output | 1 | Level DMA-enable to the attached controller |

## Verification
The reset pulse and an enable transition can come from the same write. The bench writes 0x280, which must raise `dev_rst` and `xfer_en` in the same cycle and store the word unchanged. The reset command also takes priority over drain handling. This is provoked by writing 0xC0, which must pulse `dev_rst` and keep bit 6 stored. Writes that carry only read-only bits are judged on their readback: they must store zero, not the drain substitute.

// File: rtl/chan_ctl_reg.sv
module chan_ctl_reg #(
  parameter int          W       = 32,
  parameter logic [31:0] VERSION = 32'hA000_0000,
  parameter logic [31:0] RO_MASK = 32'hFE00_0007,
  parameter int          EN_BIT  = 9,
  parameter int          RST_BIT = 7,
  parameter int          DRN_BIT = 6,
  parameter int          IRQ_BIT = 0,
  parameter int          LD_BIT  = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         irq_pend,
  input  logic         buf_loaded,
  output logic [W-1:0] rd_data,
  output logic         dev_rst,
  output logic         xfer_en
);
  localparam logic [W-1:0] WR_MASK = ~RO_MASK[W-1:0];

  logic [W-1:0] store_q;
  logic [W-1:0] cooked;
  logic         irq_q, ld_q;

  always_comb begin
    cooked = wr_data;
    if (wr_data[RST_BIT])      cooked = wr_data;
    else if (wr_data[DRN_BIT]) cooked[DRN_BIT] = 1'b0;
    else if (wr_data == '0)    cooked[DRN_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    irq_q <= irq_pend;
    ld_q  <= buf_loaded;
    if (rst) begin
      store_q <= '0;
      dev_rst <= 1'b0;
      xfer_en <= 1'b0;
    end else begin
      dev_rst <= wr_en & wr_data[RST_BIT];
      if (wr_en) begin
        store_q <= cooked & WR_MASK;
        if (cooked[EN_BIT] && !store_q[EN_BIT])      xfer_en <= 1'b1;
        else if (!cooked[EN_BIT] && store_q[EN_BIT]) xfer_en <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data          = store_q | VERSION[W-1:0];
    rd_data[IRQ_BIT] = irq_q;
    rd_data[LD_BIT]  = ld_q;
  end

  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[RST_BIT] |=> dev_rst);
  p_pulse_src_r4: assert property (@(posedge clk) disable iff (rst)
    dev_rst |-> $past(wr_en && wr_data[RST_BIT]));
  p_en_rise_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[EN_BIT] |=> xfer_en);
  p_en_fall_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_data[EN_BIT] |=> !xfer_en);
  p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(xfer_en));
  p_version_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data & VERSION[W-1:0]) == VERSION[W-1:0]);
  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    rd_data[IRQ_BIT] == $past(irq_pend) && rd_data[LD_BIT] == $past(buf_loaded));
  p_en_match_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_en == rd_data[EN_BIT]);
endmodule

// File: tb/chan_ctl_reg_tb.sv
module chan_ctl_reg_tb;
  localparam logic [31:0] VER = 32'hA000_0000;
  localparam logic [31:0] RO  = 32'hFE00_0007;

  logic clk = 0, rst = 1, wr_en = 0, irq_pend = 0, buf_loaded = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic dev_rst, xfer_en;
  int n_chk = 0, n_bad = 0;
  logic en_model = 0;

  chan_ctl_reg u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_pend(irq_pend), .buf_loaded(buf_loaded), .rd_data(rd_data),
    .dev_rst(dev_rst), .xfer_en(xfer_en));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] v);
    logic [31:0] s;
    s = v;
    if (v[7]) s = v;
    else if (v[6]) s[6] = 1'b0;
    else if (v == 0) s = 32'h40;
    s = (s & ~RO) | VER;
    s[0] = irq_pend;
    s[26] = buf_loaded;
    return s;
  endfunction

  task automatic wr(input logic [31:0] v, input string req);
    logic [31:0] e;
    @(negedge clk);
    wr_en = 1; wr_data = v;
    e = model(v);
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    if (e[9]) en_model = 1'b1; else en_model = 1'b0;
    chk(req, rd_data, e);
    chk({req, " pulse"}, {31'b0, dev_rst}, {31'b0, v[7]});
    chk({req, " enable"}, {31'b0, xfer_en}, {31'b0, en_model});
    @(negedge clk);
    chk({req, " pulse end"}, {31'b0, dev_rst}, 32'b0);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", rd_data, VER);
    rst = 0;
    @(negedge clk);
    chk("R1 after", rd_data, VER);
    chk("R1 dev_rst", {31'b0, dev_rst}, 0);
    chk("R1 xfer_en", {31'b0, xfer_en}, 0);
  endtask

  task automatic t_store;
    wr(32'h0000_0110, "R2 plain");
    wr(32'h01F0_0A28, "R2 pattern");
    wr(32'hFE00_0007, "R6 ro-only");
    wr(32'h0000_0000, "R6 zero");
    chk("R3 version", rd_data & VER, VER);
  endtask

  task automatic t_drain;
    wr(32'h0000_0050, "R5 drain");
    wr(32'h0000_0040, "R5 drain only");
  endtask

  task automatic t_rstcmd;
    wr(32'h0000_0080, "R4 reset cmd");
    wr(32'h0000_00C0, "R4 reset over drain");
  endtask

  task automatic t_enable;
    wr(32'h0000_0200, "R7 rise");
    wr(32'h0000_0210, "R8 keep high");
    repeat (4) @(negedge clk);
    chk("R8 idle hold", {31'b0, xfer_en}, 1);
    wr(32'h0000_0010, "R8 fall");
    wr(32'h0000_0100, "R8 keep low");
    wr(32'h0000_0280, "R7 rise with pulse");
    wr(32'hFFFF_FFFF, "R4 all ones");
    wr(32'h0000_0000, "R8 fall on zero");
  endtask

  task automatic t_status;
    @(negedge clk);
    irq_pend = 1; buf_loaded = 1;
    @(negedge clk);
    chk("R9 status", rd_data & 32'h0400_0001, 32'h0400_0001);
    wr(32'h0000_0000, "R9 write zero");
    wr(32'h0400_0201, "R9 write set");
    irq_pend = 0; buf_loaded = 0;
    @(negedge clk);
    chk("R9 status clear", rd_data & 32'h0400_0001, 0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_store; t_drain; t_rstcmd; t_enable; t_status;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule